// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a direct memory access controller. Software sets it up through a small word-addressed register port. The setup covers a mode word, an item count, a peripheral-side address and a memory-side address. Once the enable bit is set, the channel moves data one item at a time over a single-beat bus master port. Each item is a read beat from the source side followed by a write beat to the destination side. The two sides have their own item sizes and their own address-increment switches.

An item starts when the attached peripheral raises its request line. In memory-to-memory mode the channel does not wait for that line and runs on its own. The count falls by one after each item. The channel pulses a half-way event at the midpoint of the programmed count and a completion event when the count reaches zero. In circular mode it then reloads the count and both base addresses and keeps running. An error response on the bus ends the current item, pulses an error event and turns the channel off. Arbitration between several channels sits outside this block, and so does the collection of the events into interrupt flags.

Top module: `dma_channel_engine`

## Requirements
- R1: After reset, every register reads zero, `m_req` is low and all three event outputs are low.
- R2: Register words are selected by `reg_sel`:
  - 0 is the mode word.
  - 1 is the count. It reads back the remaining count in its low 16 bits.
  - 2 is the peripheral address.
  - 3 is the memory address.
  - 4 is a reserved word. It reads zero and ignores writes.
  - Mode word bits: 0 enable, 1 completion event enable, 2 half-way event enable, 3 error event enable, 4 direction (1 = memory to peripheral), 5 circular, 6 peripheral increment, 7 memory increment, 9:8 peripheral size, 11:10 memory size, 13:12 priority, 14 memory-to-memory.
  - Mode word bits above 14 read zero.
- R3: The lock holds while the enable bit is 1 or a beat is outstanding. Under the lock, writes to the count and to both addresses are ignored. A mode word write under the lock changes only bits 3:0, so priority, sizes and modes keep their values.
- R4: Size code 0 means 8-bit items, 1 means 16-bit items, and 2 or 3 means 32-bit items. An address with a 16-bit size is read back and issued with bit 0 cleared. With a 32-bit size, bits 1:0 are cleared. The stored address bits are kept, so alignment follows the current size.
- R5: Direction 0 reads from the peripheral address and writes to the memory address; direction 1 is the reverse. `m_size` gives the size of the side being accessed. The write data is the read data with the bytes above the destination size forced to zero.
- R6: After each item, an address whose increment bit is set advances by 1, 2 or 4, according to its own side's size. An address whose increment bit is clear stays fixed.
- R7: A new item starts only when the channel is enabled, the count is non-zero, and either `periph_req` is high or bit 14 is set.
- R8: Each completed item lowers the count by one. Outside circular mode, the channel stops issuing requests when the count reaches zero, and the enable bit stays 1.
- R9: Programmed count N, after item k (counted from 1):
  - `evt_half` pulses for one cycle when N−k equals floor(N/2).
  - `evt_done` pulses when N−k is 0.
  - Each pulse appears in the cycle after the final write acknowledge, and only if its enable bit (2 or 1) is set.
- R10: In circular mode, the item that brings the count to zero reloads the programmed count and both base addresses, and transfers go on.
- R11: `m_err` on an outstanding beat ends the item without changing the count, clears the enable bit, and pulses `evt_err` the next cycle when bit 3 is set.
- R12: `prio` always shows mode word bits 13:12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| periph_req | input | 1 | Peripheral asks for the next item |
| m_req | output | 1 | Bus beat request, held until acknowledge or error |
| m_we | output | 1 | Beat is a write |
| m_addr | output | ADDR_W | Beat address |
| m_size | output | 2 | Beat size code |
| m_wdata | output | 32 | Write data |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| m_ack | input | 1 | Beat completed |
| m_err | input | 1 | Beat failed |
| prio | output | 2 | Channel priority for an outside arbiter |
| evt_half | output | 1 | Half-way event pulse |
| evt_done | output | 1 | Completion event pulse |
| evt_err | output | 1 | Transfer error event pulse |

## Verification
The hardest state to reach from the ports is a circular channel stopped partway through a later lap. Its count and addresses must show that a reload happened and that stepping resumed from the bases. To reach it, the bench runs five items over a count of two and lowers the peripheral request inside the fifth item. The channel then stays idle, and the count and address words can be read back. An error in the middle of a run is reached by answering one read beat with an error after a normal item. A sweep over every pairing of sizes, increments and direction, with counts from one to four, covers the midpoint rule, including the case where the half-way and completion events land on the same item.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned MODE_W    = 15;

  // Mode word bit positions
  localparam int unsigned MB_EN     = 0;
  localparam int unsigned MB_TCIE   = 1;
  localparam int unsigned MB_HTIE   = 2;
  localparam int unsigned MB_TEIE   = 3;
  localparam int unsigned MB_DIR    = 4;
  localparam int unsigned MB_CIRC   = 5;
  localparam int unsigned MB_PINC   = 6;
  localparam int unsigned MB_MINC   = 7;
  localparam int unsigned MB_PSZ    = 8;
  localparam int unsigned MB_MSZ    = 10;
  localparam int unsigned MB_PRIO   = 12;
  localparam int unsigned MB_M2M    = 14;
  localparam int unsigned LOCKED_LO = 4;

  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_COUNT = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PADR  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MADR  = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } beat_state_e;

  // Address step for one item of the given size code
  function automatic logic [2:0] item_step(input logic [1:0] sz);
    case (sz)
      2'd0:    item_step = 3'd1;
      2'd1:    item_step = 3'd2;
      default: item_step = 3'd4;
    endcase
  endfunction

  // Low address bits kept for the given size code
  function automatic logic [1:0] low_keep(input logic [1:0] sz);
    case (sz)
      2'd0:    low_keep = 2'b11;
      2'd1:    low_keep = 2'b10;
      default: low_keep = 2'b00;
    endcase
  endfunction

  // Data lanes kept for the given size code
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              err_kill,
  output logic [MODE_W-1:0] mode_q,
  output logic [CW-1:0]     prog_q,
  output logic [AW-1:0]     pbase_q,
  output logic [AW-1:0]     mbase_q,
  output logic              lock,
  output logic              ld_cnt,
  output logic              ld_p,
  output logic              ld_m
);
  logic wr_mode;

  always_comb begin
    lock    = mode_q[MB_EN] | busy;
    wr_mode = wr_en && (wr_sel == SEL_MODE);
    ld_cnt  = wr_en && (wr_sel == SEL_COUNT) && !lock;
    ld_p    = wr_en && (wr_sel == SEL_PADR)  && !lock;
    ld_m    = wr_en && (wr_sel == SEL_MADR)  && !lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      prog_q  <= '0;
      pbase_q <= '0;
      mbase_q <= '0;
    end else begin
      if (wr_mode) begin
        if (lock) mode_q[LOCKED_LO-1:0] <= wr_data[LOCKED_LO-1:0];
        else      mode_q <= wr_data[MODE_W-1:0];
      end
      if (err_kill) mode_q[MB_EN] <= 1'b0;
      if (ld_cnt) prog_q  <= wr_data[CW-1:0];
      if (ld_p)   pbase_q <= wr_data[AW-1:0];
      if (ld_m)   mbase_q <= wr_data[AW-1:0];
    end
  end
endmodule

// File: rtl/dmach_addr_ctr.sv
module dmach_addr_ctr
  import dmach_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          reload,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          inc_en,
  input  logic [1:0]    sz,
  output logic [AW-1:0] cur
);
  logic [AW-1:0] raw_q;

  always_comb cur = {raw_q[AW-1:2], raw_q[1:0] & low_keep(sz)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                raw_q <= '0;
    else if (load)             raw_q <= load_val;
    else if (reload)           raw_q <= base;
    else if (advance && inc_en) raw_q <= cur + AW'(item_step(sz));
  end
endmodule

// File: rtl/dmach_xfer_fsm.sv
module dmach_xfer_fsm
  import dmach_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              m2m,
  input  logic              circ,
  input  logic              trig,
  input  logic              tcie,
  input  logic              htie,
  input  logic              teie,
  input  logic [1:0]        dst_sz,
  input  logic [CW-1:0]     prog_cnt,
  input  logic              ld_cnt,
  input  logic [CW-1:0]     cnt_wval,
  input  logic              m_ack,
  input  logic              m_err,
  input  logic [DATA_W-1:0] rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [DATA_W-1:0] wdata,
  output logic [CW-1:0]     cnt_q,
  output logic              busy,
  output logic              item_done,
  output logic              wrap,
  output logic              err_hit,
  output logic              evt_half,
  output logic              evt_done,
  output logic              evt_err
);
  beat_state_e       state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic [CW-1:0]     cnt_dec;
  logic              start, beat_ack, last_item, half_hit;

  always_comb begin
    busy      = (state_q != ST_IDLE);
    m_req     = busy;
    m_we      = (state_q == ST_WRITE);
    start     = run_en && (cnt_q != '0) && (m2m || trig);
    err_hit   = busy && m_err;
    beat_ack  = busy && m_ack && !m_err;
    item_done = m_we && beat_ack;
    cnt_dec   = cnt_q - CW'(1);
    last_item = item_done && (cnt_dec == '0);
    wrap      = last_item && circ;
    half_hit  = item_done && (cnt_dec == (prog_cnt >> 1));
    wdata     = data_q & lane_mask(dst_sz);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_READ;
      ST_READ:  if (err_hit) state_d = ST_IDLE;
                else if (beat_ack) state_d = ST_WRITE;
      ST_WRITE: if (err_hit || beat_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      data_q   <= '0;
      cnt_q    <= '0;
      evt_half <= 1'b0;
      evt_done <= 1'b0;
      evt_err  <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_READ) && beat_ack) data_q <= rdata;
      if (ld_cnt)         cnt_q <= cnt_wval;
      else if (wrap)      cnt_q <= prog_cnt;
      else if (item_done) cnt_q <= cnt_dec;
      evt_half <= half_hit && htie;
      evt_done <= last_item && tcie;
      evt_err  <= err_hit && teie;
    end
  end
endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
  import dmach_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              periph_req,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack,
  input  logic              m_err,
  output logic [1:0]        prio,
  output logic              evt_half,
  output logic              evt_done,
  output logic              evt_err
);
  localparam int unsigned SIDES = 2;
  localparam int unsigned SIDE_P = 0;
  localparam int unsigned SIDE_M = 1;

  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  prog_cnt, cnt_q;
  logic [ADDR_W-1:0] pbase, mbase;
  logic lock, ld_cnt, ld_p, ld_m, busy;
  logic item_done, wrap, err_hit;
  logic ch_en, ch_dir, ch_circ, ch_tcie;
  logic src_is_mem;

  logic [ADDR_W-1:0] side_cur  [SIDES];
  logic [ADDR_W-1:0] side_base [SIDES];
  logic              side_ld   [SIDES];
  logic              side_inc  [SIDES];
  logic [1:0]        side_sz   [SIDES];

  dmach_regs #(.AW(ADDR_W), .CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
    .busy(busy), .err_kill(err_hit), .mode_q(mode_q), .prog_q(prog_cnt),
    .pbase_q(pbase), .mbase_q(mbase), .lock(lock), .ld_cnt(ld_cnt), .ld_p(ld_p), .ld_m(ld_m)
  );

  always_comb begin
    ch_en      = mode_q[MB_EN];
    ch_dir     = mode_q[MB_DIR];
    ch_circ    = mode_q[MB_CIRC];
    ch_tcie    = mode_q[MB_TCIE];
    prio       = mode_q[MB_PRIO +: 2];
    src_is_mem = ch_dir;
    side_base[SIDE_P] = pbase;
    side_base[SIDE_M] = mbase;
    side_ld[SIDE_P]   = ld_p;
    side_ld[SIDE_M]   = ld_m;
    side_inc[SIDE_P]  = mode_q[MB_PINC];
    side_inc[SIDE_M]  = mode_q[MB_MINC];
    side_sz[SIDE_P]   = mode_q[MB_PSZ +: 2];
    side_sz[SIDE_M]   = mode_q[MB_MSZ +: 2];
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dmach_addr_ctr #(.AW(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(side_ld[s]), .load_val(reg_wdata[ADDR_W-1:0]),
      .reload(wrap), .base(side_base[s]), .advance(item_done), .inc_en(side_inc[s]),
      .sz(side_sz[s]), .cur(side_cur[s])
    );
  end

  dmach_xfer_fsm #(.CW(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run_en(ch_en), .m2m(mode_q[MB_M2M]), .circ(ch_circ),
    .trig(periph_req), .tcie(ch_tcie), .htie(mode_q[MB_HTIE]), .teie(mode_q[MB_TEIE]),
    .dst_sz(side_sz[!src_is_mem]), .prog_cnt(prog_cnt), .ld_cnt(ld_cnt),
    .cnt_wval(reg_wdata[CNT_W-1:0]), .m_ack(m_ack), .m_err(m_err), .rdata(m_rdata),
    .m_req(m_req), .m_we(m_we), .wdata(m_wdata), .cnt_q(cnt_q), .busy(busy),
    .item_done(item_done), .wrap(wrap), .err_hit(err_hit),
    .evt_half(evt_half), .evt_done(evt_done), .evt_err(evt_err)
  );

  always_comb begin
    m_addr = m_we ? side_cur[!src_is_mem] : side_cur[src_is_mem];
    m_size = m_we ? side_sz[!src_is_mem]  : side_sz[src_is_mem];
  end

  always_comb begin
    case (reg_sel)
      SEL_MODE:  reg_rdata = DATA_W'(mode_q);
      SEL_COUNT: reg_rdata = DATA_W'(cnt_q);
      SEL_PADR:  reg_rdata = DATA_W'(side_cur[SIDE_P]);
      SEL_MADR:  reg_rdata = DATA_W'(side_cur[SIDE_M]);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmach_checker.sv
module dmach_checker #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_req,
  input logic          m_we,
  input logic          m_ack,
  input logic          m_err,
  input logic [AW-1:0] m_addr,
  input logic [1:0]    m_size,
  input logic          ch_en,
  input logic          ch_circ,
  input logic          ch_tcie,
  input logic          item_done,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] prog_cnt,
  input logic          evt_done,
  input logic          lock,
  input logic          reg_wr,
  input logic [2:0]    reg_sel
);
  p_err_stops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_err) |=> !ch_en);

  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !m_err) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_size)));

  p_align16_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_size == 2'd1) |-> !m_addr[0]);

  p_align32_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_size[1]) |-> (m_addr[1:0] == 2'b00));

  p_idle_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_req && cnt_q == '0) |=> !m_req);

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && cnt_q != CW'(1)) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && cnt_q == CW'(1) && ch_circ) |=> (cnt_q == prog_cnt));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (item_done && cnt_q == CW'(1) && ch_tcie) |=> evt_done);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !item_done |=> !evt_done);

  p_lock_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd1 && lock) |=> $stable(prog_cnt));
endmodule

bind dma_channel_engine dmach_checker #(.AW(ADDR_W), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_ack(m_ack), .m_err(m_err),
  .m_addr(m_addr), .m_size(m_size), .ch_en(ch_en), .ch_circ(ch_circ), .ch_tcie(ch_tcie),
  .item_done(item_done), .cnt_q(cnt_q), .prog_cnt(prog_cnt), .evt_done(evt_done),
  .lock(lock), .reg_wr(reg_wr), .reg_sel(reg_sel)
);

// File: tb/tb_dma_channel_engine.sv
module tb_dma_channel_engine;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        periph_req = 1'b1;
  logic        m_req, m_we;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size, prio;
  logic [31:0] m_rdata = '0;
  logic        m_ack = 1'b0;
  logic        m_err = 1'b0;
  logic        evt_half, evt_done, evt_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_channel_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .periph_req(periph_req), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_ack(m_ack), .m_err(m_err), .prio(prio), .evt_half(evt_half),
    .evt_done(evt_done), .evt_err(evt_err)
  );

  function automatic logic [31:0] b_step(input int sz);
    return (sz >= 2) ? 32'd4 : (32'd1 << sz);
  endfunction
  function automatic logic [31:0] b_align(input logic [31:0] a, input int sz);
    return a & ~(b_step(sz) - 32'd1);
  endfunction
  function automatic logic [31:0] b_mask(input int sz);
    return (sz >= 2) ? 32'hFFFF_FFFF : ((32'd1 << (8 * b_step(sz))) - 32'd1);
  endfunction

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // Serve one bus beat; ev returns {err, half, done} one cycle after the response
  task automatic serve(input string req, input bit exp_we, input logic [31:0] exp_addr,
                       input logic [1:0] exp_size, input logic [31:0] rd,
                       input logic [31:0] exp_wd, input bit give_err, output logic [2:0] ev);
    int waited = 0;
    while (!m_req && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk_eq({req, " request seen"}, {31'd0, m_req}, 32'd1);
    chk_eq("R6 beat address", m_addr, exp_addr);
    chk_eq("R5 beat kind/size", {29'd0, m_we, m_size}, {29'd0, exp_we, exp_size});
    if (exp_we) chk_eq("R5 write data", m_wdata, exp_wd);
    if (give_err) m_err = 1'b1;
    else begin
      m_ack = 1'b1;
      m_rdata = rd;
    end
    @(negedge clk);
    m_ack = 1'b0; m_err = 1'b0;
    #1 ev = {evt_err, evt_half, evt_done};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [2:0]  ev;
    logic [31:0] pa, ma;

    pa = 32'h4000_0107;
    ma = 32'h2000_0A05;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      reg_read(3'(s), rv);
      chk_eq("R1 register reset", rv, 32'd0);
    end
    chk_eq("R1 outputs at reset", {28'd0, m_req, evt_half, evt_done, evt_err}, 32'd0);

    // R2 / R12 mode word readback and reserved word
    reg_write(3'd0, 32'hFFFF_7FFE);
    reg_read(3'd0, rv);
    chk_eq("R2 mode readback", rv, 32'h0000_7FFE);
    chk_eq("R12 priority output", {30'd0, prio}, 32'd3);
    reg_write(3'd4, 32'hDEAD_BEEF);
    reg_read(3'd4, rv);
    chk_eq("R2 reserved word", rv, 32'd0);
    reg_write(3'd0, 32'd0);

    // R4 alignment follows the current size
    reg_write(3'd0, (32'd1 << 8) | (32'd2 << 10));
    reg_write(3'd2, 32'h0000_0013);
    reg_write(3'd3, 32'h0000_0017);
    reg_read(3'd2, rv);
    chk_eq("R4 half-word align", rv, 32'h0000_0012);
    reg_read(3'd3, rv);
    chk_eq("R4 word align", rv, 32'h0000_0014);
    reg_write(3'd0, 32'd0);
    reg_read(3'd2, rv);
    chk_eq("R4 byte size keeps bits", rv, 32'h0000_0013);

    // R3 lock while enabled (count is zero so nothing runs)
    reg_write(3'd1, 32'd0);
    reg_write(3'd2, 32'h0000_0100);
    reg_write(3'd0, 32'h0000_1001);
    reg_write(3'd1, 32'd5);
    reg_read(3'd1, rv);
    chk_eq("R3 count write ignored", rv, 32'd0);
    reg_write(3'd2, 32'h0000_0200);
    reg_read(3'd2, rv);
    chk_eq("R3 address write ignored", rv, 32'h0000_0100);
    reg_write(3'd0, 32'h0000_2005);
    reg_read(3'd0, rv);
    chk_eq("R3 mode write under lock", rv, 32'h0000_1005);
    chk_eq("R12 priority held", {30'd0, prio}, 32'd1);
    reg_write(3'd0, 32'd0);

    // R5 R6 R8 R9 sweep over sizes, increments and direction
    for (int dir = 0; dir < 2; dir++)
      for (int ps = 0; ps < 3; ps++)
        for (int ms = 0; ms < 3; ms++)
          for (int incs = 0; incs < 4; incs++) begin
            int n;
            int ssz, dsz;
            bit sinc, dinc;
            logic [31:0] sb, db, cfg;
            n = 1 + ((ps + ms + incs + dir) % 4);
            cfg = 32'h7 | (32'(dir) << 4) | (32'(incs) << 6) | (32'(ps) << 8) | (32'(ms) << 10);
            ssz  = dir ? ms : ps;
            dsz  = dir ? ps : ms;
            sinc = dir ? incs[1] : incs[0];
            dinc = dir ? incs[0] : incs[1];
            sb   = dir ? ma : pa;
            db   = dir ? pa : ma;
            reg_write(3'd0, cfg & ~32'd1);
            reg_write(3'd1, 32'(n));
            reg_write(3'd2, pa);
            reg_write(3'd3, ma);
            reg_write(3'd0, cfg);
            for (int i = 0; i < n; i++) begin
              logic [31:0] rd, es, ed;
              bit half, done;
              rd = 32'hC3A5_5A3C ^ (32'(i) * 32'h0101_0111) ^ 32'(incs << 4);
              es = b_align(sb, ssz) + (sinc ? 32'(i) * b_step(ssz) : 32'd0);
              ed = b_align(db, dsz) + (dinc ? 32'(i) * b_step(dsz) : 32'd0);
              serve("R5", 1'b0, es, 2'(ssz), rd, 32'd0, 1'b0, ev);
              serve("R5", 1'b1, ed, 2'(dsz), 32'd0, rd & b_mask(dsz), 1'b0, ev);
              half = ((n - (i + 1)) == (n / 2));
              done = ((n - (i + 1)) == 0);
              chk_eq("R9 events", {29'd0, ev}, {29'd0, 1'b0, half, done});
            end
            repeat (3) @(negedge clk);
            chk_eq("R8 stopped at zero", {31'd0, m_req}, 32'd0);
            reg_read(3'd1, rv);
            chk_eq("R8 count zero", rv, 32'd0);
            reg_read(3'd0, rv);
            chk_eq("R8 enable kept", {31'd0, rv[0]}, 32'd1);
            reg_write(3'd0, 32'd0);
          end

    // R7 trigger gating, then memory-to-memory with events disabled (R9 gating)
    periph_req = 1'b0;
    reg_write(3'd1, 32'd2);
    reg_write(3'd2, 32'h0000_0010);
    reg_write(3'd3, 32'h0000_0080);
    reg_write(3'd0, 32'h0000_00C1);
    repeat (6) @(negedge clk);
    chk_eq("R7 no request without trigger", {31'd0, m_req}, 32'd0);
    reg_write(3'd0, 32'd0);
    reg_write(3'd0, 32'h0000_40C1);
    for (int i = 0; i < 2; i++) begin
      serve("R7", 1'b0, 32'h10 + 32'(i), 2'd0, 32'h0000_0055 + 32'(i), 32'd0, 1'b0, ev);
      serve("R7", 1'b1, 32'h80 + 32'(i), 2'd0, 32'd0, 32'h0000_0055 + 32'(i), 1'b0, ev);
      chk_eq("R9 events gated off", {29'd0, ev}, 32'd0);
    end
    reg_write(3'd0, 32'd0);
    periph_req = 1'b1;

    // R10 circular reload over five items of a count of two
    reg_write(3'd1, 32'd2);
    reg_write(3'd2, 32'h0000_0300);
    reg_write(3'd3, 32'h0000_0500);
    reg_write(3'd0, 32'h0000_00E7);
    for (int i = 0; i < 5; i++) begin
      int idx;
      idx = i % 2;
      serve("R10", 1'b0, 32'h300 + 32'(idx), 2'd0, 32'h0000_00A0 + 32'(i), 32'd0, 1'b0, ev);
      if (i == 4) periph_req = 1'b0;
      serve("R10", 1'b1, 32'h500 + 32'(idx), 2'd0, 32'd0, 32'h0000_00A0 + 32'(i), 1'b0, ev);
      chk_eq("R10 events per lap", {29'd0, ev}, {29'd0, 1'b0, idx == 0, idx == 1});
    end
    repeat (3) @(negedge clk);
    chk_eq("R10 idle after trigger drop", {31'd0, m_req}, 32'd0);
    reg_read(3'd1, rv);
    chk_eq("R10 count after reload", rv, 32'd1);
    reg_read(3'd2, rv);
    chk_eq("R10 address after reload", rv, 32'h0000_0301);
    reg_write(3'd0, 32'd0);
    periph_req = 1'b1;

    // R11 error response on the second item's read beat
    reg_write(3'd1, 32'd3);
    reg_write(3'd2, 32'h0000_0040);
    reg_write(3'd3, 32'h0000_0060);
    reg_write(3'd0, 32'h0000_00DB);
    serve("R11", 1'b0, 32'h60, 2'd0, 32'h0000_0011, 32'd0, 1'b0, ev);
    serve("R11", 1'b1, 32'h40, 2'd0, 32'd0, 32'h0000_0011, 1'b0, ev);
    serve("R11", 1'b0, 32'h61, 2'd0, 32'd0, 32'd0, 1'b1, ev);
    chk_eq("R11 error event", {29'd0, ev}, 32'h4);
    repeat (3) @(negedge clk);
    chk_eq("R11 no request after error", {31'd0, m_req}, 32'd0);
    reg_read(3'd0, rv);
    chk_eq("R11 enable cleared", {31'd0, rv[0]}, 32'd0);
    reg_read(3'd1, rv);
    chk_eq("R11 count unchanged", rv, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule